// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Frame

This block is a small memory-mapped frame that converts doorbell writes from a simple register bus into interrupt edges. Each doorbell write is decoded into a shared-peripheral interrupt number. If that number lies inside the window assigned to the frame, the block raises a one-cycle pulse on the matching bit of its interrupt output vector. If it lies outside, the block drops the write and sets a sticky error flag. Software can read a type word, which describes the window, and a fixed identification word.

The way the interrupt number is recovered is chosen by a parameter. Standard mode takes it straight from the data written to the doorbell register. Offset-data mode adds either the window base or the constant 32 to the written data. Address-only mode ignores the data and derives the number from the write address, giving each interrupt its own doorbell 8 bytes apart. A bus access completes when select and enable are both high. Accesses may follow one another in consecutive cycles.

Top module: `msi_doorbell_frame`

## Requirements
- R1: After reset no pulse is driven and the error flag is low.
- R2: A read of offset 0x008 returns the type word: the window base in bits [25:16], the window size in bits [9:0], and zeros in bits [31:26] and [15:10].
- R3: A read of offset 0xFCC returns the 32-bit identification value set by a parameter.
- R4: In standard mode, a write to offset 0x040 selects interrupt number equal to the full 32-bit write data. When that number is in the window, bit (number minus base) of spi_pulse is high for exactly the one cycle after the access.
- R5: In offset-data mode, the interrupt number is the write data plus an offset. The offset is the window base or the constant 32, chosen by a parameter. Pulse placement follows R4.
- R6: In address-only mode, every write inside the 8 KB frame is a doorbell. The interrupt number is (address >> 3) + 32, and the write data has no effect.
- R7: A doorbell whose number is outside [base, base+size-1] produces no pulse. In the cycle after the access it sets err_flag, which is also visible as bit 0 of offset 0x010. A read of 0x010 returns the flag and then clears it.
- R8: Doorbell accesses in consecutive cycles each produce their own one-cycle pulse, in order.
- R9: Reads of unmapped offsets return zero. In standard and offset-data modes, writes to any offset other than 0x040 change neither the pulses nor the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Frame select |
| penable | input | 1 | Access phase; access completes when psel and penable are high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 13 | Byte offset within the frame |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a read access |
| spi_pulse | output | NUM_SPI | One-cycle interrupt edges, bit i = base + i |
| err_flag | output | 1 | Sticky rejected-doorbell flag |

## Verification
The bench builds four frames, all with window base 40 and size 8 (interrupts 40 to 47), so both window edges and the numbers just outside them are a few steps apart. The four frames use standard mode, offset-data mode with the base as offset, offset-data mode with the constant 32, and address-only mode. With these settings the same window is reached through data values 40..47, 0..7 and 8..15, and through addresses 0x40..0x78. A data word with its top bit set shows that the range compare uses the full 32 bits.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

   typedef enum logic [1:0] {
      DEC_STANDARD    = 2'd0,
      DEC_OFFSET_DATA = 2'd1,
      DEC_ADDR_ONLY   = 2'd2
   } msi_dec_mode_e;

   localparam int unsigned PADDR_W   = 13;
   localparam int unsigned DATA_W    = 32;
   localparam int unsigned SPI_W     = 34;
   localparam int unsigned LOW_SPI   = 32;
   localparam int unsigned HIGH_SPI  = 1019;
   localparam int unsigned SLOT_SHIFT = 3;

   localparam logic [PADDR_W-1:0] OFS_TYPE     = 13'h0008;
   localparam logic [PADDR_W-1:0] OFS_STATUS   = 13'h0010;
   localparam logic [PADDR_W-1:0] OFS_DOORBELL = 13'h0040;
   localparam logic [PADDR_W-1:0] OFS_IDENT    = 13'h0FCC;

   function automatic logic [DATA_W-1:0] type_word(input int unsigned base, input int unsigned num);
      return {6'd0, 10'(base), 6'd0, 10'(num)};
   endfunction

endpackage

// File: rtl/msi_reg_read.sv
module msi_reg_read #(
   parameter int unsigned BASE_SPI = 40,
   parameter int unsigned NUM_SPI  = 8,
   parameter logic [31:0] IMPL_ID  = 32'h4D53_0001
) (
   input  logic                              rd_stb,
   input  logic [msi_frame_pkg::PADDR_W-1:0] addr,
   input  logic                              err_q,
   output logic [msi_frame_pkg::DATA_W-1:0]  rdata
);
   import msi_frame_pkg::*;

   localparam logic [DATA_W-1:0] TYPE_VAL = type_word(BASE_SPI, NUM_SPI);

   always_comb begin
      rdata = '0;
      if (rd_stb) begin
         case (addr)
            OFS_TYPE:   rdata = TYPE_VAL;
            OFS_IDENT:  rdata = IMPL_ID;
            OFS_STATUS: rdata = {{(DATA_W-1){1'b0}}, err_q};
            default:    rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/msi_spi_decode.sv
module msi_spi_decode #(
   parameter int unsigned                   BASE_SPI    = 40,
   parameter int unsigned                   NUM_SPI     = 8,
   parameter msi_frame_pkg::msi_dec_mode_e  MODE        = msi_frame_pkg::DEC_STANDARD,
   parameter bit                            OFS_IS_BASE = 1'b1,
   parameter int unsigned                   IDX_W       = 3
) (
   input  logic                              wr_stb,
   input  logic [msi_frame_pkg::PADDR_W-1:0] addr,
   input  logic [msi_frame_pkg::DATA_W-1:0]  wdata,
   output logic                              hit,
   output logic                              miss,
   output logic [IDX_W-1:0]                  idx
);
   import msi_frame_pkg::*;

   localparam logic [SPI_W-1:0] LO_LIM  = SPI_W'(BASE_SPI);
   localparam logic [SPI_W-1:0] HI_LIM  = SPI_W'(BASE_SPI + NUM_SPI);
   localparam logic [SPI_W-1:0] DATA_OFS = OFS_IS_BASE ? SPI_W'(BASE_SPI) : SPI_W'(LOW_SPI);

   logic             ring;
   logic [SPI_W-1:0] spi_num;
   logic [SPI_W-1:0] rel;

   generate
      if (MODE == DEC_ADDR_ONLY) begin : g_addr
         logic unused_wd;
         assign unused_wd = ^wdata;
         assign ring    = wr_stb;
         assign spi_num = SPI_W'(addr[PADDR_W-1:SLOT_SHIFT]) + SPI_W'(LOW_SPI);
      end else if (MODE == DEC_OFFSET_DATA) begin : g_ofs
         assign ring    = wr_stb && (addr == OFS_DOORBELL);
         assign spi_num = SPI_W'(wdata) + DATA_OFS;
      end else begin : g_std
         assign ring    = wr_stb && (addr == OFS_DOORBELL);
         assign spi_num = SPI_W'(wdata);
      end
   endgenerate

   logic in_win;
   assign in_win = (spi_num >= LO_LIM) && (spi_num < HI_LIM);
   assign rel    = spi_num - LO_LIM;

   logic [SPI_W-IDX_W-1:0] unused_rel_hi;
   assign unused_rel_hi = rel[SPI_W-1:IDX_W];

   assign hit  = ring && in_win;
   assign miss = ring && !in_win;
   assign idx  = rel[IDX_W-1:0];
endmodule

// File: rtl/msi_pulse_gen.sv
module msi_pulse_gen #(
   parameter int unsigned NUM_SPI = 8,
   parameter int unsigned IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  logic [IDX_W-1:0]   idx,
   output logic [NUM_SPI-1:0] pulse
);
   generate
      for (genvar i = 0; i < NUM_SPI; i++) begin : g_line
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse[i] <= 1'b0;
            else        pulse[i] <= fire && (idx == IDX_W'(i));
         end
      end
   endgenerate
endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame #(
   parameter int unsigned                  BASE_SPI    = 40,
   parameter int unsigned                  NUM_SPI     = 8,
   parameter msi_frame_pkg::msi_dec_mode_e MODE        = msi_frame_pkg::DEC_STANDARD,
   parameter bit                           OFS_IS_BASE = 1'b1,
   parameter logic [31:0]                  IMPL_ID     = 32'h4D53_0001
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               psel,
   input  logic               penable,
   input  logic               pwrite,
   input  logic [12:0]        paddr,
   input  logic [31:0]        pwdata,
   output logic [31:0]        prdata,
   output logic [NUM_SPI-1:0] spi_pulse,
   output logic               err_flag
);
   import msi_frame_pkg::*;

   localparam int unsigned IDX_W = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;
   localparam int unsigned SLOTS = (1 << PADDR_W) >> SLOT_SHIFT;

   generate
      if (BASE_SPI < LOW_SPI || NUM_SPI == 0 || BASE_SPI + NUM_SPI > HIGH_SPI) begin : g_bad_window
         $error("interrupt window outside the legal range");
      end
      if (MODE == DEC_ADDR_ONLY && BASE_SPI + NUM_SPI - LOW_SPI > SLOTS) begin : g_bad_span
         $error("window does not fit the address-only frame");
      end
   endgenerate

   logic access, wr_stb, rd_stb;
   assign access = psel && penable;
   assign wr_stb = access && pwrite;
   assign rd_stb = access && !pwrite;

   logic             hit, miss;
   logic [IDX_W-1:0] idx;
   logic             err_q;

   msi_spi_decode #(
      .BASE_SPI(BASE_SPI), .NUM_SPI(NUM_SPI), .MODE(MODE),
      .OFS_IS_BASE(OFS_IS_BASE), .IDX_W(IDX_W)
   ) u_decode (
      .wr_stb(wr_stb), .addr(paddr), .wdata(pwdata),
      .hit(hit), .miss(miss), .idx(idx)
   );

   msi_pulse_gen #(.NUM_SPI(NUM_SPI), .IDX_W(IDX_W)) u_pulse (
      .clk(clk), .rst_n(rst_n), .fire(hit), .idx(idx), .pulse(spi_pulse)
   );

   msi_reg_read #(.BASE_SPI(BASE_SPI), .NUM_SPI(NUM_SPI), .IMPL_ID(IMPL_ID)) u_read (
      .rd_stb(rd_stb), .addr(paddr), .err_q(err_q), .rdata(prdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   err_q <= 1'b0;
      else if (miss)                                err_q <= 1'b1;
      else if (rd_stb && paddr == OFS_STATUS)       err_q <= 1'b0;
   end

   assign err_flag = err_q;
endmodule

// File: rtl/msi_doorbell_frame_chk.sv
module msi_doorbell_frame_chk #(
   parameter int unsigned NUM_SPI = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               psel,
   input logic               penable,
   input logic               pwrite,
   input logic [12:0]        paddr,
   input logic [NUM_SPI-1:0] spi_pulse,
   input logic               err_flag
);
   // R4: at most one interrupt line pulses per cycle
   a_r4_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(spi_pulse));

   // R4: a pulse only follows a completed write access
   a_r4_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_pulse != '0) |-> $past(psel && penable && pwrite));

   // R7: a rejected doorbell raises the flag without a pulse
   a_r7_err_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> (spi_pulse == '0));

   // R7: the flag only drops after a read of the status offset
   a_r7_err_clear_by_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_flag) |-> $past(psel && penable && !pwrite && paddr == msi_frame_pkg::OFS_STATUS));

   // R9: a read never produces a pulse
   a_r9_read_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $past(psel && penable && !pwrite) |-> (spi_pulse == '0));
endmodule

bind msi_doorbell_frame msi_doorbell_frame_chk #(.NUM_SPI(NUM_SPI)) u_chk (
   .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
   .paddr(paddr), .spi_pulse(spi_pulse), .err_flag(err_flag)
);

// File: tb/tb_msi_doorbell_frame.sv
`timescale 1ns/1ps
module tb_msi_doorbell_frame;
   localparam int NF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [NF-1:0] sel = '0;
   logic          penable = 1'b0, pwrite = 1'b0;
   logic [12:0]   paddr = '0;
   logic [31:0]   pwdata = '0;
   logic [31:0]   prd [NF];
   logic [7:0]    pul [NF];
   logic          err [NF];

   msi_doorbell_frame #(.MODE(msi_frame_pkg::DEC_STANDARD)) dut (
      .clk(clk), .rst_n(rst_n), .psel(sel[0]), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prd[0]), .spi_pulse(pul[0]), .err_flag(err[0]));
   msi_doorbell_frame #(.MODE(msi_frame_pkg::DEC_OFFSET_DATA), .OFS_IS_BASE(1'b1)) dut_ob (
      .clk(clk), .rst_n(rst_n), .psel(sel[1]), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prd[1]), .spi_pulse(pul[1]), .err_flag(err[1]));
   msi_doorbell_frame #(.MODE(msi_frame_pkg::DEC_OFFSET_DATA), .OFS_IS_BASE(1'b0)) dut_oc (
      .clk(clk), .rst_n(rst_n), .psel(sel[2]), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prd[2]), .spi_pulse(pul[2]), .err_flag(err[2]));
   msi_doorbell_frame #(.MODE(msi_frame_pkg::DEC_ADDR_ONLY)) dut_ad (
      .clk(clk), .rst_n(rst_n), .psel(sel[3]), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prd[3]), .spi_pulse(pul[3]), .err_flag(err[3]));

   typedef struct { int who; logic [7:0] vec; string req; } exp_t;
   exp_t expq[$];

   int n_checks = 0, n_errors = 0;
   bit finished = 0;
   logic [31:0] rd_val;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   // monitor: pops one expected pulse vector per completed write
   logic acc_wr_q = 1'b0;
   int   who_q = 0;
   int   cur_who = 0;
   always @(posedge clk) begin
      acc_wr_q <= (|sel) && penable && pwrite;
      who_q    <= cur_who;
   end
   always @(negedge clk) begin
      if (rst_n) begin
         if (acc_wr_q) begin
            exp_t e;
            if (expq.size() == 0) check("R4 unexpected write", 32'(pul[who_q]), 32'hDEAD);
            else begin
               e = expq.pop_front();
               check(e.req, 32'(pul[e.who]), 32'(e.vec));
            end
         end else begin
            for (int k = 0; k < NF; k++)
               if (pul[k] !== 8'h00) check("R4 idle pulse", 32'(pul[k]), 32'h0);
         end
      end
   end

   task automatic wr(input int who, input logic [12:0] a, input logic [31:0] d,
                     input logic [7:0] exp, input string req);
      expq.push_back('{who: who, vec: exp, req: req});
      @(negedge clk);
      cur_who = who; sel = '0; sel[who] = 1'b1; penable = 1'b0; pwrite = 1'b1;
      paddr = a; pwdata = d;
      @(negedge clk); penable = 1'b1;
      @(negedge clk); sel = '0; penable = 1'b0;
   endtask

   task automatic rd(input int who, input logic [12:0] a);
      @(negedge clk);
      cur_who = who; sel = '0; sel[who] = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      @(negedge clk); penable = 1'b1;
      #1 rd_val = prd[who];
      @(negedge clk); sel = '0; penable = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      for (int k = 0; k < NF; k++) begin
         check("R1 reset pulse", 32'(pul[k]), 32'h0);
         check("R1 reset flag", 32'(err[k]), 32'h0);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      rd(0, 13'h008); check("R2 type word", rd_val, 32'h0028_0008);
      rd(3, 13'h008); check("R2 type word addr-only", rd_val, 32'h0028_0008);
      rd(0, 13'hFCC); check("R3 ident", rd_val, 32'h4D53_0001);
      rd(0, 13'h100); check("R9 unmapped read", rd_val, 32'h0);

      wr(0, 13'h008, 32'hFFFF_FFFF, 8'h00, "R9 write to type");
      rd(0, 13'h008); check("R9 type after write", rd_val, 32'h0028_0008);
      wr(0, 13'h044, 32'd40, 8'h00, "R9 write off doorbell");
      check("R9 flag after stray write", 32'(err[0]), 32'h0);

      wr(0, 13'h040, 32'd40, 8'h01, "R4 low edge");
      wr(0, 13'h040, 32'd47, 8'h80, "R4 high edge");
      wr(0, 13'h040, 32'd44, 8'h10, "R4 middle");
      check("R7 no flag on valid", 32'(err[0]), 32'h0);

      wr(0, 13'h040, 32'd39, 8'h00, "R7 below window");
      check("R7 flag set", 32'(err[0]), 32'h1);
      rd(0, 13'h010); check("R7 status reads set", rd_val, 32'h1);
      check("R7 flag cleared", 32'(err[0]), 32'h0);
      rd(0, 13'h010); check("R7 status after clear", rd_val, 32'h0);
      wr(0, 13'h040, 32'd48, 8'h00, "R7 above window");
      check("R7 flag above", 32'(err[0]), 32'h1);
      rd(0, 13'h010);
      wr(0, 13'h040, 32'h8000_0028, 8'h00, "R7 wide data");
      check("R7 flag wide data", 32'(err[0]), 32'h1);
      rd(0, 13'h010);

      // R8: two doorbells in consecutive cycles
      expq.push_back('{who: 0, vec: 8'h02, req: "R8 first"});
      expq.push_back('{who: 0, vec: 8'h04, req: "R8 second"});
      @(negedge clk);
      cur_who = 0; sel = 4'b0001; penable = 1'b0; pwrite = 1'b1; paddr = 13'h040; pwdata = 32'd41;
      @(negedge clk); penable = 1'b1;
      @(negedge clk); pwdata = 32'd42;
      @(negedge clk); sel = '0; penable = 1'b0;

      wr(1, 13'h040, 32'd3, 8'h08, "R5 base offset");
      wr(1, 13'h040, 32'd8, 8'h00, "R5 base offset out");
      check("R5 base offset flag", 32'(err[1]), 32'h1);
      wr(2, 13'h040, 32'd8, 8'h01, "R5 const offset low");
      wr(2, 13'h040, 32'd15, 8'h80, "R5 const offset high");
      wr(2, 13'h040, 32'd7, 8'h00, "R5 const offset out");
      check("R5 const offset flag", 32'(err[2]), 32'h1);

      wr(3, 13'h0050, 32'hFFFF_FFFF, 8'h04, "R6 addr slot 42");
      wr(3, 13'h0078, 32'h0000_0000, 8'h80, "R6 addr slot 47");
      wr(3, 13'h0040, 32'd99, 8'h01, "R6 addr slot 40");
      check("R6 no flag", 32'(err[3]), 32'h0);
      wr(3, 13'h0038, 32'd40, 8'h00, "R6 slot 39 rejected");
      check("R6 flag low slot", 32'(err[3]), 32'h1);
      rd(3, 13'h010);
      wr(3, 13'h0080, 32'd44, 8'h00, "R6 slot 48 rejected");
      check("R6 flag high slot", 32'(err[3]), 32'h1);

      repeat (3) @(negedge clk);
      check("R4 queue drained", 32'(expq.size()), 32'h0);
      finish_run();
   end
endmodule